// File: doc/BRIEF.md
# Transmit Preamble, Auto-Pad and FCS Inserter

This block sits in the byte-wide transmit path of a 10 Mb/s Ethernet MAC, between the host-side frame stream and the serialiser. A frame arrives as a valid/ready byte stream with a first-byte and a last-byte marker. The block puts the preamble and start delimiter in front of the frame and forwards the data bytes. If the pad control is set, it fills short frames with zero bytes. If the controls call for it, it then appends a CRC-32 frame check sequence.

Padding depends only on a running count of bits emitted since the first preamble bit. The length/type field inside the frame is never read. The same count is brought out on `bit_count` so that later stages, such as slot-time and collision logic, can use it. Both controls are sampled once, when the frame starts.

The controller has five states:
- IDLE goes to PREAMBLE when a first-marked byte is offered.
- PREAMBLE goes to DATA after its eighth byte.
- DATA goes to PAD, FCS or IDLE when the last-marked byte is accepted.
- PAD goes to FCS once the count reaches the pad threshold.
- FCS goes back to IDLE after its fourth byte.

Top module: `tx_pad_fcs`

## Requirements
- R1: After reset, `out_valid`, `in_ready`, `out_first`, `out_last` are 0 and `bit_count` is 0.
- R2: When `in_valid` and `in_first` are seen in IDLE, output starts the following cycle with eight consecutive bytes: seven 0x55 then 0xD5. `out_first` is 1 only on the first of them.
- R3: In DATA, input bytes are forwarded unchanged and in order in the same cycle they are accepted. A cycle with `in_valid` low emits nothing.
- R4: `bit_count` is cleared at frame start, rises by 8 in the cycle after each emitted byte, and holds its value after the frame ends.
- R5: When `pad_en` is 1 (sampled at frame start) and fewer than 544 bits have been emitted after the last data byte, 0x00 bytes follow until exactly 544 bits have been emitted.
- R6: No pad byte is emitted when `pad_en` is 0, or when 544 or more bits have already been emitted after the last data byte.
- R7: The frame's length/type field (data bytes 12 and 13) has no effect on the amount of padding.
- R8: Four FCS bytes are appended when `fcs_off` is 0 or `pad_en` is 1 (both sampled at frame start). Otherwise the frame ends with its last data byte.
- R9: The FCS is a CRC-32 with polynomial 0x04C11DB7 and the register preset to all ones. It is fed most significant bit first over the data and pad bytes, and then inverted. Bits 31:24 are sent first and bits 7:0 last.
- R10: With `pad_en` set, a frame of 60 or fewer data bytes totals 576 bits (72 bytes) on the output.
- R11: `out_last` is 1 on exactly the final byte of a frame, and `out_valid` is 0 in the cycle after it.
- R12: `in_ready` is 0 during PREAMBLE, PAD and FCS and in IDLE, so that exactly the frame's data bytes are consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pad_en | input | 1 | Enable automatic padding to the minimum frame |
| fcs_off | input | 1 | Suppress FCS when padding is off |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block accepts an input byte |
| in_data | input | 8 | Input frame byte |
| in_first | input | 1 | Input byte is the first of a frame |
| in_last | input | 1 | Input byte is the last of a frame |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_first | output | 1 | First preamble byte |
| out_last | output | 1 | Final byte of the frame |
| bit_count | output | CNT_W | Bits emitted since the first preamble bit |

## Verification
- **Output bytes:** the output is combinational from state and input, so each output byte appears in the same cycle as the state that produces it. The first preamble byte appears one cycle after the start offer, and a data byte appears in the cycle it is accepted.
- **Bit count:** `bit_count` is a register and trails each emitted byte by one cycle.
- **Drive and sample timing:** the bench drives inputs at the falling edge, samples outputs 1 ns later in the same half-cycle, and counts a handshake only from those sampled values. It reads the held `bit_count` and the idle `out_valid` one cycle after the byte marked `out_last`.
- **Coverage:** data lengths 1 to 70 are swept under all four control combinations, with input gaps and varying length-field contents. Every expected byte comes from arithmetic in the bench.

// File: rtl/tx_pad_fcs_pkg.sv
package tx_pad_fcs_pkg;

    typedef enum logic [2:0] {
        S_IDLE     = 3'd0,
        S_PREAMBLE = 3'd1,
        S_DATA     = 3'd2,
        S_PAD      = 3'd3,
        S_FCS      = 3'd4
    } tx_state_e;

    localparam int          CRC_W      = 32;
    localparam int          FCS_BYTES  = CRC_W / 8;
    localparam logic [31:0] CRC_POLY   = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_PRESET = 32'hFFFF_FFFF;
    localparam logic [7:0]  PRE_BYTE   = 8'h55;
    localparam logic [7:0]  SFD_BYTE   = 8'hD5;
    localparam logic [7:0]  FILL_BYTE  = 8'h00;

    // One byte of CRC update, most significant data bit first.
    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            if (r[31] ^ b[i]) r = (r << 1) ^ CRC_POLY;
            else              r = r << 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/tx_crc32.sv
module tx_crc32
    import tx_pad_fcs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  data,
    output logic [31:0] crc
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr) crc <= CRC_PRESET;
        else if (en)       crc <= crc_step(crc, data);
    end
endmodule

// File: rtl/tx_bit_counter.sv
module tx_bit_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] STEP = CNT_W'(8);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) count <= '0;
        else if (inc)      count <= count + STEP;
    end

    assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |=> (count == $past(count) + STEP));
endmodule

// File: rtl/tx_pad_fcs.sv
module tx_pad_fcs
    import tx_pad_fcs_pkg::*;
#(
    parameter int PRE_BYTES       = 8,
    parameter int MIN_FRAME_BYTES = 64,
    parameter int CNT_W           = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pad_en,
    input  logic             fcs_off,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_data,
    input  logic             in_first,
    input  logic             in_last,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_first,
    output logic             out_last,
    output logic [CNT_W-1:0] bit_count
);
    localparam int               PAD_LIMIT = (PRE_BYTES + MIN_FRAME_BYTES - FCS_BYTES) * 8;
    localparam int               IDX_W     = $clog2(PRE_BYTES > FCS_BYTES ? PRE_BYTES : FCS_BYTES) + 1;
    localparam logic [CNT_W-1:0] LIMIT_C   = CNT_W'(PAD_LIMIT);
    localparam logic [CNT_W-1:0] BYTE_BITS = CNT_W'(8);
    localparam logic [IDX_W-1:0] PRE_END   = IDX_W'(PRE_BYTES - 1);
    localparam logic [IDX_W-1:0] FCS_END   = IDX_W'(FCS_BYTES - 1);

    tx_state_e        state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic             pad_q, fcs_q;
    logic             start, take_last, short_now, fcs_need;
    logic [31:0]      crc, fcs_sel;
    logic [CNT_W-1:0] count_after;

    assign start       = (state_q == S_IDLE) && in_valid && in_first;
    assign take_last   = (state_q == S_DATA) && in_valid && in_last;
    assign count_after = bit_count + BYTE_BITS;
    assign short_now   = count_after < LIMIT_C;
    assign fcs_need    = pad_q || fcs_q;
    assign fcs_sel     = ~crc << (8 * int'(idx_q));

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (start) state_d = S_PREAMBLE;
            S_PREAMBLE: if (idx_q == PRE_END) state_d = S_DATA;
            S_DATA:     if (take_last) begin
                            if (pad_q && short_now) state_d = S_PAD;
                            else if (fcs_need)      state_d = S_FCS;
                            else                    state_d = S_IDLE;
                        end
            S_PAD:      if (!short_now) state_d = S_FCS;
            S_FCS:      if (idx_q == FCS_END) state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // State register, byte index and controls latched at frame start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
            pad_q   <= 1'b0;
            fcs_q   <= 1'b1;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) idx_q <= '0;
            else                    idx_q <= idx_q + IDX_W'(1);
            if (start) begin
                pad_q <= pad_en;
                fcs_q <= !fcs_off;
            end
        end
    end

    // Outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = FILL_BYTE;
        out_first = 1'b0;
        out_last  = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_PREAMBLE: begin
                out_valid = 1'b1;
                out_data  = (idx_q == PRE_END) ? SFD_BYTE : PRE_BYTE;
                out_first = (idx_q == '0);
            end
            S_DATA: begin
                in_ready  = 1'b1;
                out_valid = in_valid;
                out_data  = in_data;
                out_last  = take_last && !fcs_need && !(pad_q && short_now);
            end
            S_PAD: begin
                out_valid = 1'b1;
                out_data  = FILL_BYTE;
            end
            S_FCS: begin
                out_valid = 1'b1;
                out_data  = fcs_sel[31:24];
                out_last  = (idx_q == FCS_END);
            end
            default: ;
        endcase
    end

    tx_crc32 u_crc (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (start),
        .en   (out_valid && (state_q == S_DATA || state_q == S_PAD)),
        .data (out_data),
        .crc  (crc)
    );

    tx_bit_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (start),
        .inc  (out_valid),
        .count(bit_count)
    );

    // Assertions
    assert_first_is_preamble_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_first |-> (out_data == PRE_BYTE && bit_count == '0));
    assert_pad_below_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PAD) |-> (bit_count < LIMIT_C));
    assert_fcs_after_min_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FCS && pad_q) |-> (bit_count >= LIMIT_C));
    assert_crc_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FCS && idx_q != '0) |-> $stable(crc));
    assert_idle_after_last_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |=> !out_valid);
    assert_no_take_outside_data_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && in_valid) |-> out_valid);
endmodule

// File: tb/tx_pad_fcs_test.sv
module tx_pad_fcs_test;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pad_en = 1'b0, fcs_off = 1'b0;
    logic             in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
    logic [7:0]       in_data = 8'h00;
    logic             in_ready, out_valid, out_first, out_last;
    logic [7:0]       out_data;
    logic [CNT_W-1:0] bit_count;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    tx_pad_fcs #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .pad_en(pad_en), .fcs_off(fcs_off),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_first(in_first), .in_last(in_last), .out_valid(out_valid),
        .out_data(out_data), .out_first(out_first), .out_last(out_last),
        .bit_count(bit_count)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails  = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] crc_upd(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            if (r[31] ^ b[i]) r = (r << 1) ^ 32'h04C11DB7;
            else              r = r << 1;
        end
        return r;
    endfunction

    task automatic run_frame(input int n, input bit pe, input bit fo);
        logic [7:0]  din [0:127];
        logic [7:0]  exp [0:255];
        logic [7:0]  got [0:255];
        logic [31:0] c;
        int idx = 0, nout = 0, cyc = 0, last_pos = -1, p, f, elen;
        int byte_bad = 0, pre_bad = 0, fcs_bad = 0, data_bad = 0;
        bit done = 0, ready_bad = 0, first_bad = 0, gap;

        for (int i = 0; i < n; i++) din[i] = 8'((i * 29 + n * 7 + 3) & 255);
        if (n > 13) begin
            din[12] = n[0] ? 8'h05 : 8'h00;   // R7: length field varies per frame
            din[13] = 8'((n * 53) & 255);
        end
        p    = (pe && n < 60) ? 60 - n : 0;
        f    = (pe || !fo) ? 4 : 0;
        elen = 8 + n + p + f;
        for (int i = 0; i < 7; i++) exp[i] = 8'h55;
        exp[7] = 8'hD5;
        c = 32'hFFFFFFFF;
        for (int i = 0; i < n + p; i++) begin
            exp[8 + i] = (i < n) ? din[i] : 8'h00;
            c = crc_upd(c, exp[8 + i]);
        end
        c = ~c;
        for (int i = 0; i < f; i++) exp[8 + n + p + i] = 8'(c >> (24 - 8 * i));

        while (!done && cyc < 1000) begin
            @(negedge clk);
            pad_en  = pe;
            fcs_off = fo;
            cyc++;
            gap = (cyc % 7 == 4) && idx > 0;
            in_valid = (idx < n) && !gap;
            in_data  = din[idx < n ? idx : 0];
            in_first = (idx == 0);
            in_last  = (idx == n - 1);
            #1;
            if (out_valid) begin
                if (nout < 256) got[nout] = out_data;
                if (out_first != (nout == 0)) first_bad = 1;
                if (in_ready && (nout < 8 || nout >= 8 + n)) ready_bad = 1;
                if (out_last) begin
                    last_pos = nout;
                    done = 1;
                end
                nout++;
            end
            if (in_valid && in_ready) idx++;
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_first = 1'b0;
        in_last  = 1'b0;
        #1;
        check(!out_valid, "R11 idle after last", int'(out_valid), 0);
        check(bit_count == CNT_W'(nout * 8), "R4 held bit count", int'(bit_count), nout * 8);
        check(last_pos == elen - 1, "R11 last position", last_pos, elen - 1);
        check(nout == elen, (p > 0) ? "R5 padded length" : "R6 unpadded length", nout, elen);
        if (pe && n <= 60) check(nout * 8 == 576, "R10 minimum frame bits", nout * 8, 576);
        if (n > 13) check(nout == elen, "R7 length field ignored", nout, elen);
        check(idx == n && !ready_bad, "R12 consumed bytes", idx, n);
        check(!first_bad, "R2 first marker", int'(first_bad), 0);
        for (int i = 0; i < nout && i < elen && i < 256; i++) begin
            if (got[i] != exp[i]) begin
                byte_bad++;
                if (i < 8) pre_bad++;
                else if (i < 8 + n) data_bad++;
                else if (i >= 8 + n + p) fcs_bad++;
            end
        end
        check(pre_bad == 0, "R2 preamble bytes", pre_bad, 0);
        check(data_bad == 0, "R3 data bytes", data_bad, 0);
        check(fcs_bad == 0 && (f == 4) == (nout == 12 + n + p), "R8 R9 FCS bytes", fcs_bad, 0);
        check(byte_bad == 0, "R5 pad and stream bytes", byte_bad, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(!out_valid && !in_ready && !out_first && !out_last, "R1 reset outputs",
              int'({out_valid, in_ready, out_first, out_last}), 0);
        check(bit_count == '0, "R1 reset bit count", int'(bit_count), 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int cfg = 0; cfg < 4; cfg++) begin
            for (int n = 1; n <= 70; n++) begin
                run_frame(n, cfg[1], cfg[0]);
            end
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule